// File: doc/BRIEF.md
# Compact Flash Multiword DMA Engine

This block moves one contiguous buffer of 16-bit words between a memory port and an IDE-style storage device, using the multiword DMA handshake. Software programs a single configuration write. It carries the enable, the direction, a 20-bit word count in minus-one form, the start address, a byte-exchange flag, a memory byte-order flag and a flag that decides what a dropped device request means. The engine then waits for the device request and asserts the acknowledge. It strobes the read or write line once per word, counts the words down and advances the address. When the count wraps to all ones it releases the device, clears its enable and sets a sticky done bit, which can raise an interrupt.

Every phase width comes from a timing field. The read/write strobe assert and negate times, the acknowledge setup and hold, and the pause after a dropped request are each scaled by a fixed clock multiplier. The request sample delay counts raw clocks. An inversion input sets the polarity of the acknowledge pin.

Memory reads use a request channel (`mrd_valid`/`mrd_ready`) and an unthrottled return strobe (`mrd_dvalid`). Only one read is ever outstanding. Memory writes use `mwr_valid`/`mwr_ready`. The engine waits as long as the memory withholds ready, and holds its request steady while it waits.

Top module: `cf_mwdma_engine`

## Requirements
- R1: After reset, and whenever no transfer is enabled, `busy_o`, `done_o`, `irq_o`, `dior_o` and `diow_o` are 0. `dmack_o` equals `ack_invert`, and `size_o` reads all ones.
- R2: A transfer programmed with `cfg_size` = N moves N+1 words. `size_o` drops by one per word and `addr_o` rises by 2 per word, so a completed transfer leaves `size_o` = 0xFFFFF and `addr_o` = start + 2(N+1).
- R3: When a transfer ends, `busy_o` falls and `done_o` rises on the same clock edge.
- R4: `done_o` stays set until a cycle with `done_clr` = 1 clears it. `irq_o` is 1 exactly when `done_o` and `irq_en` are both 1.
- R5: With `cfg_dir` = 0, words flow from the device to memory: the engine pulses `dior_o` and issues memory writes. With `cfg_dir` = 1, words flow from memory to the device: the engine issues memory reads and pulses `diow_o`. The two strobes are never high together, and neither is high unless the acknowledge is active.
- R6: Each word has its high byte (bits 15:8) and low byte (bits 7:0) exchanged when `cfg_swap` XOR `cfg_endian` is 1, and passes unchanged otherwise.
- R7: With `cfg_stop_on_drop` = 0, a request that is low when the next word is due pauses the transfer. The engine then releases the acknowledge and stays busy, then resumes when the request returns, and ends with the full word count.
- R8: With `cfg_stop_on_drop` = 1, a request that is low when the next word is due ends the transfer early. `busy_o` clears, `done_o` sets, and `size_o` holds N minus the number of words moved.
- R9: A configuration write with `cfg_en` = 0 and `cfg_size` all ones stops the engine at once. The engine becomes idle, `size_o` reads all ones, and `done_o` is not set.
- R10: Each read or write strobe stays high for (`tim_active`+1)×4 clocks. In a device-to-memory transfer, the acknowledge is active for (`tim_ack_setup`+1)×4 clocks before the first strobe.
- R11: `dmack_o` is the active-high acknowledge XOR `ack_invert`.
- R12: `mrd_valid`, once raised, stays high with a stable `mrd_addr` until `mrd_ready` is seen. Read data is taken on `mrd_dvalid` without back-pressure, and a stalled memory changes no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_en | input | 1 | Enable the transfer |
| cfg_dir | input | 1 | 0 device to memory, 1 memory to device |
| cfg_swap | input | 1 | Byte exchange flag |
| cfg_endian | input | 1 | Memory byte-order flag, combined with swap by XOR |
| cfg_stop_on_drop | input | 1 | 1: a dropped request ends the transfer |
| cfg_size | input | 20 | Word count minus one |
| cfg_addr | input | 32 | Start byte address |
| tim_active | input | 6 | Strobe assert width, ×4 clocks |
| tim_recover | input | 6 | Strobe negate width, ×4 clocks |
| tim_ack_setup | input | 6 | Acknowledge setup, ×4 clocks |
| tim_ack_hold | input | 6 | Acknowledge hold, ×4 clocks |
| tim_pause | input | 6 | Pause after a dropped request, ×4 clocks |
| tim_rq_delay | input | 4 | Request sample delay, raw clocks minus one |
| ack_invert | input | 1 | Invert acknowledge pin |
| done_clr | input | 1 | Clear done |
| irq_en | input | 1 | Interrupt enable |
| busy_o | output | 1 | Enable status |
| done_o | output | 1 | Sticky done |
| irq_o | output | 1 | Interrupt |
| size_o | output | 20 | Remaining count, minus-one form |
| addr_o | output | 32 | Current byte address |
| dmarq_i | input | 1 | Device DMA request |
| dmack_o | output | 1 | Device DMA acknowledge |
| dior_o | output | 1 | Read strobe, active high |
| diow_o | output | 1 | Write strobe, active high |
| dev_wdata_o | output | 16 | Data to device |
| dev_wdata_oe | output | 1 | Device data drive enable |
| dev_rdata_i | input | 16 | Data from device |
| mrd_valid | output | 1 | Memory read request |
| mrd_ready | input | 1 | Memory read accept |
| mrd_addr | output | 32 | Memory read address |
| mrd_dvalid | input | 1 | Memory read data valid |
| mrd_data | input | 16 | Memory read data |
| mwr_valid | output | 1 | Memory write request |
| mwr_ready | input | 1 | Memory write accept |
| mwr_addr | output | 32 | Memory write address |
| mwr_data | output | 16 | Memory write data |

## Verification
A corrupted sequencer state shows up on the device pins within one phase, at most (63+1)×4 clocks. It appears as a strobe of the wrong width, a strobe outside the acknowledge, or both strobes at once. A counter that misses or doubles a step shows up at `size_o` and `addr_o` on the very next edge, and again at the end as a residue other than all ones. A wrong byte path or a lost back-pressure stall shows up only when the moved words are compared with their sources, after the transfer ends.

// File: rtl/cf_dma_pkg.sv
package cf_dma_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_WAITRQ, ST_SETUP, ST_FETCH, ST_FWAIT, ST_STROBE,
    ST_RECOV, ST_PUSH, ST_GAP, ST_HOLD, ST_PAUSE
  } cf_state_e;

  typedef enum logic [1:0] {
    END_NONE, END_FINISH, END_STOP, END_PAUSE
  } cf_end_e;
endpackage

// File: rtl/cf_phase_timer.sv
module cf_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/cf_word_swap.sv
module cf_word_swap #(
  parameter int WW = 16
) (
  input  logic          swap,
  input  logic [WW-1:0] din,
  output logic [WW-1:0] dout
);
  localparam int NB = WW / 8;
  logic [WW-1:0] flipped;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign flipped[b*8 +: 8] = din[(NB-1-b)*8 +: 8];
  end

  assign dout = swap ? flipped : din;
endmodule

// File: rtl/cf_xfer_counter.sv
module cf_xfer_counter #(
  parameter int SW = 20,
  parameter int AW = 32,
  parameter int STEP = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [SW-1:0] load_size,
  input  logic [AW-1:0] load_addr,
  input  logic          step,
  output logic [SW-1:0] size,
  output logic [AW-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size <= '1;
      addr <= '0;
    end else if (load) begin
      size <= load_size;
      addr <= load_addr;
    end else if (step) begin
      size <= size - 1'b1;
      addr <= addr + AW'(STEP);
    end
  end
endmodule

// File: rtl/cf_mwdma_engine.sv
module cf_mwdma_engine
  import cf_dma_pkg::*;
#(
  parameter int SW   = 20,
  parameter int AW   = 32,
  parameter int WW   = 16,
  parameter int TW   = 6,
  parameter int DW   = 4,
  parameter int MULT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_en,
  input  logic          cfg_dir,
  input  logic          cfg_swap,
  input  logic          cfg_endian,
  input  logic          cfg_stop_on_drop,
  input  logic [SW-1:0] cfg_size,
  input  logic [AW-1:0] cfg_addr,
  input  logic [TW-1:0] tim_active,
  input  logic [TW-1:0] tim_recover,
  input  logic [TW-1:0] tim_ack_setup,
  input  logic [TW-1:0] tim_ack_hold,
  input  logic [TW-1:0] tim_pause,
  input  logic [DW-1:0] tim_rq_delay,
  input  logic          ack_invert,
  input  logic          done_clr,
  input  logic          irq_en,
  output logic          busy_o,
  output logic          done_o,
  output logic          irq_o,
  output logic [SW-1:0] size_o,
  output logic [AW-1:0] addr_o,
  input  logic          dmarq_i,
  output logic          dmack_o,
  output logic          dior_o,
  output logic          diow_o,
  output logic [WW-1:0] dev_wdata_o,
  output logic          dev_wdata_oe,
  input  logic [WW-1:0] dev_rdata_i,
  output logic          mrd_valid,
  input  logic          mrd_ready,
  output logic [AW-1:0] mrd_addr,
  input  logic          mrd_dvalid,
  input  logic [WW-1:0] mrd_data,
  output logic          mwr_valid,
  input  logic          mwr_ready,
  output logic [AW-1:0] mwr_addr,
  output logic [WW-1:0] mwr_data
);
  localparam int CW = TW + $clog2(MULT) + 1;

  cf_state_e     state_q, state_n;
  cf_end_e       end_q, end_n;
  logic          en_q, dir_q, swap_q, stop_drop_q, done_q;
  logic [WW-1:0] wdata_q, rdata_q, mem_sw, dev_sw;
  logic          tmr_load, tmr_exp, step_c, finish_c, cap_mem, cap_dev, dmack_act;
  logic [CW-1:0] tmr_val;

  // Phase length in clocks = (field + 1) * MULT; timer holds length - 1.
  function automatic logic [CW-1:0] scaled(input logic [TW-1:0] f);
    logic [CW-1:0] w;
    w = CW'(f) + 1'b1;
    return CW'(w * CW'(MULT)) - 1'b1;
  endfunction

  cf_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
  );

  cf_xfer_counter #(.SW(SW), .AW(AW), .STEP(WW / 8)) u_count (
    .clk(clk), .rst_n(rst_n), .load(cfg_wr), .load_size(cfg_size), .load_addr(cfg_addr),
    .step(step_c && !cfg_wr), .size(size_o), .addr(addr_o)
  );

  cf_word_swap #(.WW(WW)) u_swap_mem (.swap(swap_q), .din(mrd_data),    .dout(mem_sw));
  cf_word_swap #(.WW(WW)) u_swap_dev (.swap(swap_q), .din(dev_rdata_i), .dout(dev_sw));

  always_comb begin
    state_n  = state_q;
    end_n    = end_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    step_c   = 1'b0;
    finish_c = 1'b0;
    cap_mem  = 1'b0;
    cap_dev  = 1'b0;
    unique case (state_q)
      ST_IDLE:   if (en_q) state_n = ST_WAITRQ;
      ST_WAITRQ: if (dmarq_i) begin
        state_n = ST_SETUP; tmr_load = 1'b1; tmr_val = scaled(tim_ack_setup);
      end
      ST_SETUP:  if (tmr_exp) begin
        if (dir_q) state_n = ST_FETCH;
        else begin state_n = ST_STROBE; tmr_load = 1'b1; tmr_val = scaled(tim_active); end
      end
      ST_FETCH:  if (mrd_ready) state_n = ST_FWAIT;
      ST_FWAIT:  if (mrd_dvalid) begin
        cap_mem = 1'b1; state_n = ST_STROBE; tmr_load = 1'b1; tmr_val = scaled(tim_active);
      end
      ST_STROBE: if (tmr_exp) begin
        cap_dev = !dir_q; state_n = ST_RECOV; tmr_load = 1'b1; tmr_val = scaled(tim_recover);
      end
      ST_RECOV:  if (tmr_exp) begin
        if (dir_q) begin
          step_c = 1'b1; state_n = ST_GAP; tmr_load = 1'b1; tmr_val = CW'(tim_rq_delay);
        end else state_n = ST_PUSH;
      end
      ST_PUSH:   if (mwr_ready) begin
        step_c = 1'b1; state_n = ST_GAP; tmr_load = 1'b1; tmr_val = CW'(tim_rq_delay);
      end
      ST_GAP:    if (tmr_exp) begin
        if (size_o == '1) begin
          end_n = END_FINISH; state_n = ST_HOLD; tmr_load = 1'b1; tmr_val = scaled(tim_ack_hold);
        end else if (dmarq_i) begin
          if (dir_q) state_n = ST_FETCH;
          else begin state_n = ST_STROBE; tmr_load = 1'b1; tmr_val = scaled(tim_active); end
        end else begin
          end_n = stop_drop_q ? END_STOP : END_PAUSE;
          state_n = ST_HOLD; tmr_load = 1'b1; tmr_val = scaled(tim_ack_hold);
        end
      end
      ST_HOLD:   if (tmr_exp) begin
        if (end_q == END_PAUSE) begin
          state_n = ST_PAUSE; tmr_load = 1'b1; tmr_val = scaled(tim_pause);
        end else begin
          state_n = ST_IDLE; finish_c = 1'b1;
        end
      end
      ST_PAUSE:  if (tmr_exp) begin state_n = ST_WAITRQ; end_n = END_NONE; end
      default:   state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      end_q       <= END_NONE;
      en_q        <= 1'b0;
      dir_q       <= 1'b0;
      swap_q      <= 1'b0;
      stop_drop_q <= 1'b0;
      done_q      <= 1'b0;
      wdata_q     <= '0;
      rdata_q     <= '0;
    end else begin
      if (cfg_wr) begin
        state_q     <= ST_IDLE;
        end_q       <= END_NONE;
        en_q        <= cfg_en;
        dir_q       <= cfg_dir;
        swap_q      <= cfg_swap ^ cfg_endian;
        stop_drop_q <= cfg_stop_on_drop;
      end else begin
        state_q <= state_n;
        end_q   <= end_n;
        if (finish_c) en_q <= 1'b0;
      end
      if (finish_c && !cfg_wr) done_q <= 1'b1;
      else if (done_clr)       done_q <= 1'b0;
      if (cap_mem) wdata_q <= mem_sw;
      if (cap_dev) rdata_q <= dev_sw;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_IDLE, ST_WAITRQ, ST_PAUSE: dmack_act = 1'b0;
      default:                      dmack_act = 1'b1;
    endcase
  end

  assign busy_o       = en_q;
  assign done_o       = done_q;
  assign irq_o        = done_q && irq_en;
  assign dmack_o      = dmack_act ^ ack_invert;
  assign dior_o       = (state_q == ST_STROBE) && !dir_q;
  assign diow_o       = (state_q == ST_STROBE) && dir_q;
  assign dev_wdata_o  = wdata_q;
  assign dev_wdata_oe = dmack_act && dir_q;
  assign mrd_valid    = (state_q == ST_FETCH);
  assign mrd_addr     = addr_o;
  assign mwr_valid    = (state_q == ST_PUSH);
  assign mwr_addr     = addr_o;
  assign mwr_data     = rdata_q;
endmodule

// File: rtl/cf_mwdma_engine_chk.sv
module cf_mwdma_engine_chk #(
  parameter int SW = 20,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr,
  input logic          ack_invert,
  input logic          busy_o,
  input logic          done_o,
  input logic [SW-1:0] size_o,
  input logic [AW-1:0] addr_o,
  input logic          dmack_o,
  input logic          dior_o,
  input logic          diow_o,
  input logic          mrd_valid,
  input logic          mrd_ready,
  input logic [AW-1:0] mrd_addr
);
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(dior_o && diow_o));

  assert_strobe_in_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dior_o || diow_o) |-> (dmack_o != ack_invert));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (dmack_o == ack_invert) && !dior_o && !diow_o);

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_wr) && (size_o != $past(size_o)))
      |-> (size_o == $past(size_o) - 1'b1) && (addr_o == $past(addr_o) + 2'd2));

  assert_done_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> !busy_o && $past(busy_o));

  assert_rd_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_valid && !mrd_ready && !cfg_wr) |=> mrd_valid && $stable(mrd_addr));
endmodule

bind cf_mwdma_engine cf_mwdma_engine_chk #(.SW(SW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .ack_invert(ack_invert),
  .busy_o(busy_o), .done_o(done_o), .size_o(size_o), .addr_o(addr_o),
  .dmack_o(dmack_o), .dior_o(dior_o), .diow_o(diow_o),
  .mrd_valid(mrd_valid), .mrd_ready(mrd_ready), .mrd_addr(mrd_addr)
);

// File: tb/cf_mwdma_engine_bench.sv
`timescale 1ns/1ps
module cf_mwdma_engine_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cfg_wr = 0, cfg_en = 0, cfg_dir = 0, cfg_swap = 0, cfg_endian = 0, cfg_stop_on_drop = 0;
  logic [19:0] cfg_size = '0;
  logic [31:0] cfg_addr = '0;
  logic [5:0]  tim_active = 6'd2, tim_recover = 6'd0, tim_ack_setup = 6'd1, tim_ack_hold = 6'd0, tim_pause = 6'd1;
  logic [3:0]  tim_rq_delay = 4'd2;
  logic ack_invert = 0, done_clr = 0, irq_en = 1;
  logic busy_o, done_o, irq_o, dmack_o, dior_o, diow_o, dev_wdata_oe;
  logic [19:0] size_o;
  logic [31:0] addr_o, mrd_addr, mwr_addr;
  logic [15:0] dev_wdata_o, dev_rdata_i, mwr_data;
  logic [15:0] mrd_data = '0;
  logic mrd_valid, mwr_valid, mrd_ready, mwr_ready, dmarq_i;
  logic mrd_dvalid = 0;

  logic [15:0] mem_src [64];
  logic [15:0] mem_sink[64];
  logic [15:0] dev_src [64];
  logic [15:0] dev_sink[64];

  int checks = 0, errors = 0;
  logic dmarq_on = 0, stall_mode = 0;
  int drop_after = 0, strobe_base = 0, rd_base = 0, wr_base = 0;
  int strobe_cnt = 0, rd_falls = 0, wr_falls = 0, cur_w = 0, last_w = 0;
  int setup_cnt = 0, last_setup = 0, viol = 0;
  logic seen = 0, prev_dior = 0, prev_diow = 0, prev_mv = 0, prev_mr = 0;
  logic [31:0] prev_ma = '0;
  logic [1:0] stall_cnt = '0;

  cf_mwdma_engine u_cf_mwdma_engine (.*);

  assign dmarq_i     = dmarq_on && !(drop_after != 0 && (strobe_cnt - strobe_base) >= drop_after);
  assign dev_rdata_i = dev_src[6'(rd_falls - rd_base)];
  assign mrd_ready   = !stall_mode || (stall_cnt == 2'd0);
  assign mwr_ready   = !stall_mode || (stall_cnt == 2'd1);

  always @(posedge clk) begin
    stall_cnt  <= (stall_cnt == 2'd2) ? 2'd0 : stall_cnt + 2'd1;
    mrd_dvalid <= mrd_valid && mrd_ready;
    if (mrd_valid && mrd_ready) mrd_data <= mem_src[mrd_addr[6:1]];
    if (mwr_valid && mwr_ready) mem_sink[mwr_addr[6:1]] <= mwr_data;
  end

  always @(negedge clk) begin
    if ((prev_dior || prev_diow) && !(dior_o || diow_o)) begin
      last_w = cur_w; cur_w = 0; strobe_cnt++;
    end
    if (dior_o || diow_o) cur_w++;
    if (prev_dior && !dior_o) rd_falls++;
    if (prev_diow && !diow_o) begin
      dev_sink[6'(wr_falls - wr_base)] = dev_wdata_o; wr_falls++;
    end
    if (!busy_o) begin seen = 0; setup_cnt = 0; end
    else if ((dior_o || diow_o) && !seen) begin seen = 1; last_setup = setup_cnt; end
    else if ((dmack_o ^ ack_invert) && !seen) setup_cnt++;
    if (prev_mv && !prev_mr && (!mrd_valid || mrd_addr != prev_ma)) viol++;
    prev_dior = dior_o; prev_diow = diow_o;
    prev_mv = mrd_valid; prev_mr = mrd_ready; prev_ma = mrd_addr;
  end

  function automatic logic [15:0] sw(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start(input logic dir, input logic swp, input logic end_f, input logic stopd,
                       input logic [19:0] size, input logic [31:0] addr);
    @(negedge clk);
    strobe_base = strobe_cnt; rd_base = rd_falls; wr_base = wr_falls;
    cfg_en = 1; cfg_dir = dir; cfg_swap = swp; cfg_endian = end_f; cfg_stop_on_drop = stopd;
    cfg_size = size; cfg_addr = addr; cfg_wr = 1; done_clr = 1;
    @(negedge clk);
    cfg_wr = 0; done_clr = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy_o; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy_o, 0); chk("R1 done", done_o, 0); chk("R1 irq", irq_o, 0);
    chk("R1 size", size_o, 20'hFFFFF); chk("R1 dmack", dmack_o, 0);
    chk("R1 strobes", {dior_o, diow_o}, 0);
  endtask

  task automatic t_dev_to_mem();
    dmarq_on = 1; drop_after = 0;
    start(0, 0, 0, 0, 20'd7, 32'h1000);
    chk("R3 busy while running", busy_o, 1);
    wait_idle();
    for (int k = 0; k < 8; k++) chk("R5 dev->mem word", mem_sink[k], dev_src[k]);
    chk("R2 size end", size_o, 20'hFFFFF); chk("R2 addr end", addr_o, 32'h1010);
    chk("R3 done", done_o, 1); chk("R4 irq", irq_o, 1);
    chk("R10 strobe width", last_w, 12); chk("R10 ack setup", last_setup, 8);
  endtask

  task automatic t_done_clear();
    @(negedge clk); done_clr = 1; @(negedge clk); done_clr = 0;
    chk("R4 done cleared", done_o, 0); chk("R4 irq cleared", irq_o, 0);
  endtask

  task automatic t_mem_to_dev();
    stall_mode = 1; viol = 0;
    start(1, 1, 0, 0, 20'd5, 32'h1000);
    wait_idle();
    for (int k = 0; k < 6; k++) chk("R6 R12 mem->dev swapped word", dev_sink[k], sw(mem_src[k]));
    chk("R12 request held", viol, 0); chk("R2 size end", size_o, 20'hFFFFF);
    chk("R5 no dev->mem strobes", rd_falls - rd_base, 0);
    stall_mode = 0;
  endtask

  task automatic t_endian();
    irq_en = 0;
    start(0, 1, 1, 0, 20'd3, 32'h1010);
    wait_idle();
    for (int k = 0; k < 4; k++) chk("R6 swap^endian unchanged", mem_sink[8+k], dev_src[k]);
    chk("R4 done with irq off", done_o, 1); chk("R4 irq gated", irq_o, 0);
    irq_en = 1;
  endtask

  task automatic t_pause();
    drop_after = 2;
    start(0, 0, 0, 0, 20'd5, 32'h1020);
    repeat (150) @(negedge clk);
    chk("R7 still busy", busy_o, 1); chk("R7 size held", size_o, 20'd3);
    chk("R7 ack released", dmack_o, 0);
    drop_after = 0;
    wait_idle();
    for (int k = 0; k < 6; k++) chk("R7 word after resume", mem_sink[16+k], dev_src[k]);
    chk("R7 size end", size_o, 20'hFFFFF);
  endtask

  task automatic t_stop_drop();
    drop_after = 3;
    start(0, 0, 0, 1, 20'd7, 32'h1030);
    wait_idle();
    chk("R8 busy", busy_o, 0); chk("R8 done", done_o, 1);
    chk("R8 residue", size_o, 20'd4); chk("R8 addr", addr_o, 32'h1036);
    for (int k = 0; k < 3; k++) chk("R8 moved word", mem_sink[24+k], dev_src[k]);
    drop_after = 0;
  endtask

  task automatic t_stop_cmd();
    dmarq_on = 0;
    start(0, 0, 0, 0, 20'd3, 32'h1000);
    repeat (20) @(negedge clk);
    chk("R9 waiting busy", busy_o, 1);
    cfg_en = 0; cfg_size = 20'hFFFFF; cfg_wr = 1; @(negedge clk); cfg_wr = 0;
    @(negedge clk);
    chk("R9 idle", busy_o, 0); chk("R9 size", size_o, 20'hFFFFF);
    chk("R9 no done", done_o, 0); chk("R9 strobes", {dior_o, diow_o, dmack_o}, 0);
    dmarq_on = 1;
  endtask

  task automatic t_polarity();
    @(negedge clk); ack_invert = 1; @(negedge clk);
    chk("R11 idle pin", dmack_o, 1);
    start(0, 0, 0, 0, 20'd1, 32'h1000);
    wait_idle();
    chk("R11 setup seen inverted", last_setup, 8); chk("R11 done", done_o, 1);
    chk("R11 idle pin after", dmack_o, 1);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem_src[i] = {8'(8'h10 + i), 8'(8'h80 + i)};
      dev_src[i] = {8'(8'h40 + i), 8'(8'hC0 + i)};
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_dev_to_mem();
    t_done_clear();
    t_mem_to_dev();
    t_endian();
    t_pause();
    t_stop_drop();
    t_done_clear();
    t_stop_cmd();
    t_polarity();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule